// File: doc/BRIEF.md
# Command Status and Data FIFO Engine

This block is the device side of a byte-wide command/response register interface. The host writes a command into a shared buffer one byte at a time through a single data port. It polls a status byte that says whether more command bytes are expected, and it then writes a go bit. The block hands the buffer to an internal executor and waits for it to return a response in the same buffer. The host then drains the response through the same data port and may rewind it to read it again.

A live 16-bit transfer allowance tells the host how many data-port accesses it may make before it has to poll again. While a command is coming in, the allowance is the free buffer space. While a response is waiting, it is the number of unread bytes. It is capped at a configured ceiling, and a value of zero means the host must wait. The command length is taken from the command itself, from bytes 2 to 5 in big-endian order. Writing the ready bit discards any command or response in progress.

The reset input is asynchronous and active-low. Its release is expected to be synchronised to `clk` outside the block.

Top module: `cmd_fifo_engine`

## Requirements
- R1: After reset the status byte reads 0xC0 (bit 7 valid, bit 6 command-ready) and the transfer allowance equals min(DEPTH, BURST_MAX).
- R2: The first accepted data byte sets the expect flag (status bit 3). The flag stays set until the received count reaches the required length or DEPTH, whichever comes first, and then clears.
- R3: The required length is the big-endian 32-bit value in command bytes 2..5, with a minimum of 6. Before byte 5 has arrived, the required length is 6.
- R4: The allowance reads DEPTH minus the bytes received while expect is set, zero once expect has cleared, zero while executing, and the unread response count while responding. It never exceeds BURST_MAX.
- R5: A go write (status bit 5) with a complete command pulses exe_start for one cycle, with exe_cmd_len equal to the bytes received. A go write while expect is set, or in any other state, is ignored.
- R6: exe_done during execution sets data-available (status bit 4, status 0x90). The response length is exe_rsp_len capped at DEPTH.
- R7: Data-port reads return the response bytes in buffer order. Data-available clears after the last byte is read, and any read after that returns 0x00.
- R8: A retry write (status bit 1) while responding rewinds the read position to byte 0, so the whole response is returned again.
- R9: A ready write (status bit 6) in any state returns to the ready state (status 0xC0, full allowance) and discards the partial command or response. The next command starts at buffer offset 0.
- R10: A cancel write (bit 0 at offset 0x1B) or a ready write during execution pulses exe_abort for one cycle and returns to ready. A later exe_done is ignored.
- R11: Data writes are ignored while the engine is not accepting: once expect has cleared, during execution, and while responding.
- R12: Register offsets are: status byte at 0x18, allowance low byte at 0x19 and high byte at 0x1A, cancel at 0x1B bit 0, and the data port at 0x24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Read byte, valid the cycle after reg_rd |
| exe_start | output | 1 | One-cycle pulse: command ready for the executor |
| exe_abort | output | 1 | One-cycle pulse: execution cancelled |
| exe_cmd_len | output | PTR_W | Number of command bytes in the buffer |
| exe_addr | input | PTR_W | Executor buffer address |
| exe_we | input | 1 | Executor buffer write enable (honoured only while executing) |
| exe_wdata | input | 8 | Executor response byte |
| exe_rdata | output | 8 | Buffer byte at exe_addr |
| exe_done | input | 1 | Executor finished; response length on exe_rsp_len |
| exe_rsp_len | input | PTR_W | Response length in bytes |

## Verification
On every cycle, the assertions check that expect and data-available are never set together and that the allowance stays at or below its ceiling. They also check that exe_start and exe_abort are single-cycle pulses, that an abort always lands in the ready state, and that each data read during a response advances the read position by exactly one without passing the response length. Only the bench scenarios can show the actual values: the big-endian length decode and the six-byte minimum, the cap at buffer depth, the ignored go and data writes, and the byte order of a response before and after a retry. The same applies to the discarded partial command and the executor completion that is ignored after a cancel.

// File: rtl/cfe_pkg.sv
package cfe_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_RECV  = 2'd1,
    ST_EXEC  = 2'd2,
    ST_RESP  = 2'd3
  } cfe_state_e;

  localparam int OFS_STS    = 'h18;
  localparam int OFS_BCL    = 'h19;
  localparam int OFS_BCH    = 'h1A;
  localparam int OFS_CANCEL = 'h1B;
  localparam int OFS_FIFO   = 'h24;

  localparam int BIT_VALID  = 7;
  localparam int BIT_READY  = 6;
  localparam int BIT_GO     = 5;
  localparam int BIT_AVAIL  = 4;
  localparam int BIT_EXPECT = 3;
  localparam int BIT_RETRY  = 1;
  localparam int BIT_CANCEL = 0;

  localparam int HDR_LEN    = 6;
endpackage

// File: rtl/cfe_buffer.sv
module cfe_buffer #(
  parameter int DEPTH = 1280,
  parameter int PTR_W = 11
) (
  input  logic             clk,
  input  logic             we,
  input  logic [PTR_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [PTR_W-1:0] raddr_a,
  output logic [7:0]       rdata_a,
  input  logic [PTR_W-1:0] raddr_b,
  output logic [7:0]       rdata_b
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (waddr < LIMIT)) mem[waddr] <= wdata;
  end

  always_comb begin
    rdata_a = (raddr_a < LIMIT) ? mem[raddr_a] : 8'h00;
    rdata_b = (raddr_b < LIMIT) ? mem[raddr_b] : 8'h00;
  end
endmodule

// File: rtl/cfe_regs.sv
module cfe_regs import cfe_pkg::*; #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [7:0]    wdata,
  input  logic [7:0]    status,
  input  logic [15:0]   burst,
  input  logic [7:0]    fifo_byte,
  input  logic          avail,
  output logic          acc_wr,
  output logic          cmd_ready,
  output logic          cmd_go,
  output logic          cmd_retry,
  output logic          cmd_cancel,
  output logic          fifo_rd,
  output logic [7:0]    rdata
);
  logic       sts_hit;
  logic [7:0] rdata_d;

  always_comb begin
    sts_hit    = (addr == AW'(OFS_STS));
    cmd_ready  = wr && sts_hit && wdata[BIT_READY];
    cmd_go     = wr && sts_hit && wdata[BIT_GO];
    cmd_retry  = wr && sts_hit && wdata[BIT_RETRY];
    cmd_cancel = wr && (addr == AW'(OFS_CANCEL)) && wdata[BIT_CANCEL];
    acc_wr     = wr && (addr == AW'(OFS_FIFO));
    fifo_rd    = rd && (addr == AW'(OFS_FIFO));
  end

  always_comb begin
    rdata_d = 8'h00;
    if (addr == AW'(OFS_STS))       rdata_d = status;
    else if (addr == AW'(OFS_BCL))  rdata_d = burst[7:0];
    else if (addr == AW'(OFS_BCH))  rdata_d = burst[15:8];
    else if (addr == AW'(OFS_FIFO)) rdata_d = avail ? fifo_byte : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (rd) rdata <= rdata_d;
  end
endmodule

// File: rtl/cfe_ctrl.sv
module cfe_ctrl import cfe_pkg::*; #(
  parameter int DEPTH = 1280,
  parameter int PTR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_wr,
  input  logic [7:0]       acc_byte,
  input  logic             cmd_ready,
  input  logic             cmd_go,
  input  logic             cmd_retry,
  input  logic             cmd_cancel,
  input  logic             fifo_rd,
  input  logic             exe_done,
  input  logic [PTR_W-1:0] exe_rsp_len,
  output cfe_state_e       st,
  output logic [PTR_W-1:0] wr_cnt,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] rsp_len,
  output logic             expect_more,
  output logic             avail,
  output logic             host_we,
  output logic             exe_start,
  output logic             exe_abort
);
  localparam logic [31:0]      DEPTH32 = 32'(DEPTH);
  localparam logic [31:0]      HDR32   = 32'(HDR_LEN);
  localparam logic [PTR_W-1:0] LIMIT   = PTR_W'(DEPTH);

  cfe_state_e       st_q, st_d;
  logic [PTR_W-1:0] cnt_q, cnt_d, rd_q, rd_d, rsp_q, rsp_d;
  logic [31:0]      len_q, len_d, need, cnt32;
  logic             go_ok, abort_now, start_q, abort_q;

  always_comb begin
    cnt32       = 32'(cnt_q);
    need        = (cnt32 < HDR32 || len_q < HDR32) ? HDR32 : len_q;
    expect_more = (st_q == ST_RECV) && (cnt32 < need) && (cnt32 < DEPTH32);
    avail       = (st_q == ST_RESP) && (rd_q < rsp_q);
    host_we     = acc_wr && ((st_q == ST_READY) || expect_more);
    go_ok       = cmd_go && !cmd_ready && (st_q == ST_RECV) && !expect_more;
    abort_now   = (st_q == ST_EXEC) && (cmd_ready || cmd_cancel);
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    len_d = len_q;
    rd_d  = rd_q;
    rsp_d = rsp_q;
    if (cmd_ready) begin
      st_d  = ST_READY;
      cnt_d = '0;
      len_d = '0;
      rd_d  = '0;
      rsp_d = '0;
    end else begin
      case (st_q)
        ST_READY: if (host_we) begin
          st_d  = ST_RECV;
          cnt_d = PTR_W'(1);
        end
        ST_RECV: begin
          if (host_we) begin
            cnt_d = cnt_q + PTR_W'(1);
            if (cnt32 >= 32'd2 && cnt32 <= 32'd5) len_d = {len_q[23:0], acc_byte};
          end else if (go_ok) begin
            st_d = ST_EXEC;
          end
        end
        ST_EXEC: begin
          if (cmd_cancel) begin
            st_d  = ST_READY;
            cnt_d = '0;
            len_d = '0;
          end else if (exe_done) begin
            st_d  = ST_RESP;
            rd_d  = '0;
            rsp_d = (exe_rsp_len > LIMIT) ? LIMIT : exe_rsp_len;
          end
        end
        ST_RESP: begin
          if (cmd_retry)              rd_d = '0;
          else if (fifo_rd && avail)  rd_d = rd_q + PTR_W'(1);
        end
        default: st_d = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_READY;
      cnt_q   <= '0;
      len_q   <= '0;
      rd_q    <= '0;
      rsp_q   <= '0;
      start_q <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      if (cnt_d != cnt_q) cnt_q <= cnt_d;
      if (len_d != len_q) len_q <= len_d;
      if (rd_d != rd_q)   rd_q  <= rd_d;
      if (rsp_d != rsp_q) rsp_q <= rsp_d;
      start_q <= go_ok;
      abort_q <= abort_now;
    end
  end

  assign st        = st_q;
  assign wr_cnt    = cnt_q;
  assign rd_ptr    = rd_q;
  assign rsp_len   = rsp_q;
  assign exe_start = start_q;
  assign exe_abort = abort_q;
endmodule

// File: rtl/cmd_fifo_engine.sv
module cmd_fifo_engine import cfe_pkg::*; #(
  parameter int AW        = 8,
  parameter int DEPTH     = 1280,
  parameter int BURST_MAX = 64,
  parameter int PTR_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             exe_start,
  output logic             exe_abort,
  output logic [PTR_W-1:0] exe_cmd_len,
  input  logic [PTR_W-1:0] exe_addr,
  input  logic             exe_we,
  input  logic [7:0]       exe_wdata,
  output logic [7:0]       exe_rdata,
  input  logic             exe_done,
  input  logic [PTR_W-1:0] exe_rsp_len
);
  localparam logic [PTR_W-1:0] LIMIT = PTR_W'(DEPTH);

  cfe_state_e       st;
  logic [PTR_W-1:0] wr_cnt, rd_ptr, rsp_len, raw_cnt, buf_waddr;
  logic             sts_expect, sts_avail, host_we, ready_bit;
  logic             acc_wr, cmd_ready, cmd_go, cmd_retry, cmd_cancel, fifo_rd;
  logic             buf_we;
  logic [7:0]       buf_wdata, fifo_byte, status;
  logic [15:0]      burst_val;

  cfe_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .status(status), .burst(burst_val),
    .fifo_byte(fifo_byte), .avail(sts_avail), .acc_wr(acc_wr),
    .cmd_ready(cmd_ready), .cmd_go(cmd_go), .cmd_retry(cmd_retry),
    .cmd_cancel(cmd_cancel), .fifo_rd(fifo_rd), .rdata(reg_rdata)
  );

  cfe_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_byte(reg_wdata),
    .cmd_ready(cmd_ready), .cmd_go(cmd_go), .cmd_retry(cmd_retry),
    .cmd_cancel(cmd_cancel), .fifo_rd(fifo_rd), .exe_done(exe_done),
    .exe_rsp_len(exe_rsp_len), .st(st), .wr_cnt(wr_cnt), .rd_ptr(rd_ptr),
    .rsp_len(rsp_len), .expect_more(sts_expect), .avail(sts_avail),
    .host_we(host_we), .exe_start(exe_start), .exe_abort(exe_abort)
  );

  always_comb begin
    if (st == ST_EXEC) begin
      buf_we    = exe_we;
      buf_waddr = exe_addr;
      buf_wdata = exe_wdata;
    end else begin
      buf_we    = host_we;
      buf_waddr = wr_cnt;
      buf_wdata = reg_wdata;
    end
  end

  cfe_buffer #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr_a(rd_ptr), .rdata_a(fifo_byte),
    .raddr_b(exe_addr), .rdata_b(exe_rdata)
  );

  always_comb begin
    ready_bit = (st == ST_READY) || (st == ST_RECV);
    status    = '0;
    status[BIT_VALID]  = 1'b1;
    status[BIT_READY]  = ready_bit;
    status[BIT_AVAIL]  = sts_avail;
    status[BIT_EXPECT] = sts_expect;
    case (st)
      ST_READY: raw_cnt = LIMIT;
      ST_RECV:  raw_cnt = sts_expect ? (LIMIT - wr_cnt) : '0;
      ST_RESP:  raw_cnt = rsp_len - rd_ptr;
      default:  raw_cnt = '0;
    endcase
  end

  generate
    if (BURST_MAX < DEPTH) begin : g_sat
      assign burst_val = (32'(raw_cnt) > 32'(BURST_MAX)) ? 16'(BURST_MAX) : 16'(raw_cnt);
    end else begin : g_nosat
      assign burst_val = 16'(raw_cnt);
    end
  endgenerate

  assign exe_cmd_len = wr_cnt;
endmodule

// File: rtl/cmd_fifo_engine_chk.sv
module cmd_fifo_engine_chk #(
  parameter int BURST_MAX = 64,
  parameter int PTR_W     = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exe_start,
  input logic             exe_abort,
  input logic             avail,
  input logic             expect_more,
  input logic             ready_bit,
  input logic [15:0]      burst,
  input logic [PTR_W-1:0] rd_ptr,
  input logic [PTR_W-1:0] rsp_len,
  input logic             fifo_rd,
  input logic             retry_w,
  input logic             ready_w
);
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(avail && expect_more));

  assert_burst_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(burst) <= 32'(BURST_MAX));

  assert_start_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exe_start |=> !exe_start);

  assert_abort_to_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exe_abort |-> (ready_bit && !avail && !expect_more));

  assert_abort_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exe_abort |=> !exe_abort);

  assert_rdptr_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= rsp_len);

  assert_read_advance_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (avail && fifo_rd && !retry_w && !ready_w) |=> (rd_ptr == $past(rd_ptr) + PTR_W'(1)));
endmodule

bind cmd_fifo_engine cmd_fifo_engine_chk #(.BURST_MAX(BURST_MAX), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .exe_start(exe_start), .exe_abort(exe_abort),
  .avail(sts_avail), .expect_more(sts_expect), .ready_bit(ready_bit),
  .burst(burst_val), .rd_ptr(rd_ptr), .rsp_len(rsp_len), .fifo_rd(fifo_rd),
  .retry_w(cmd_retry), .ready_w(cmd_ready)
);

// File: tb/cmd_fifo_engine_tb.sv
module cmd_fifo_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 1280;
  localparam int BMAX       = 1024;
  localparam int PW         = 11;
  localparam logic [7:0] A_STS = 8'h18, A_BCL = 8'h19, A_BCH = 8'h1A,
                         A_CAN = 8'h1B, A_FIFO = 8'h24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0, reg_wdata = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_rdata;
  logic          exe_start, exe_abort;
  logic [PW-1:0] exe_cmd_len;
  logic [PW-1:0] exe_addr = '0, exe_rsp_len = '0;
  logic          exe_we = 1'b0, exe_done = 1'b0;
  logic [7:0]    exe_wdata = '0, exe_rdata;

  int n_chk = 0, n_bad = 0, n_start = 0, n_abort = 0;
  logic [PW-1:0] last_len = '0;
  logic [7:0] cmd [0:2047];
  int cmd_n = 1;
  logic [7:0] exp_q [$];
  logic mon_pend = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cmd_fifo_engine #(.AW(8), .DEPTH(DEPTH), .BURST_MAX(BMAX), .PTR_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .exe_start(exe_start), .exe_abort(exe_abort), .exe_cmd_len(exe_cmd_len),
    .exe_addr(exe_addr), .exe_we(exe_we), .exe_wdata(exe_wdata),
    .exe_rdata(exe_rdata), .exe_done(exe_done), .exe_rsp_len(exe_rsp_len)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // executor-side pulses counted from the ports
  always @(posedge clk) begin
    if (exe_start) begin n_start <= n_start + 1; last_len <= exe_cmd_len; end
    if (exe_abort) n_abort <= n_abort + 1;
    mon_pend <= reg_rd && (reg_addr == A_FIFO);
  end

  // scoreboard monitor: every data-port read is compared against the queue
  always @(negedge clk) begin
    if (mon_pend) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R7: data read %0h with no expected byte queued", reg_rdata);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (reg_rdata !== e) begin
          n_bad++;
          $display("FAIL R7/R8: data read actual %0h expected %0h", reg_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask

  task automatic chk_sts(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    rd(A_STS, v);
    chk({tag, " status"}, 32'(v), 32'(exp));
  endtask

  task automatic chk_burst(input string tag, input int exp);
    logic [7:0] lo, hi;
    rd(A_BCL, lo);
    rd(A_BCH, hi);
    chk({tag, " allowance R12"}, {16'h0, hi, lo}, 32'(exp));
  endtask

  task automatic send(input int from, input int to);
    for (int i = from; i < to; i++) wr(A_FIFO, cmd[i]);
  endtask

  task automatic set_hdr(input logic [7:0] b1, input logic [31:0] len);
    cmd[0] = 8'h80; cmd[1] = b1;
    cmd[2] = len[31:24]; cmd[3] = len[23:16]; cmd[4] = len[15:8]; cmd[5] = len[7:0];
  endtask

  task automatic exec_rsp(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); exe_addr = PW'(i); exe_wdata = cmd[i % cmd_n] ^ 8'hA5; exe_we = 1'b1;
    end
    @(negedge clk); exe_we = 1'b0; exe_rsp_len = PW'(n); exe_done = 1'b1;
    @(negedge clk); exe_done = 1'b0;
  endtask

  task automatic fifo_pull(input logic [7:0] exp);
    logic [7:0] v;
    exp_q.push_back(exp);
    rd(A_FIFO, v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_sts("R1 reset", 8'hC0);
    chk_burst("R1/R4 reset saturated", BMAX);

    // Command A: 10 bytes
    set_hdr(8'h01, 32'd10);
    cmd[6] = 8'h11; cmd[7] = 8'h22; cmd[8] = 8'h33; cmd[9] = 8'h44; cmd_n = 10;
    send(0, 1);
    chk_sts("R2 first byte sets expect", 8'hC8);
    chk_burst("R4 free space saturated", BMAX);
    send(1, 3);
    wr(A_STS, 8'h20);
    repeat (3) @(negedge clk);
    chk("R5 go ignored while expecting", 32'(n_start), 32'd0);
    chk_sts("R5 state kept after early go", 8'hC8);
    send(3, 10);
    chk_sts("R2/R3 expect clears at length", 8'hC0);
    chk_burst("R4 zero after complete", 0);
    wr(A_FIFO, 8'hEE);
    chk("R11 extra byte ignored", 32'(exe_cmd_len), 32'd10);
    wr(A_STS, 8'h20);
    repeat (3) @(negedge clk);
    chk("R5 start pulse", 32'(n_start), 32'd1);
    chk("R5 command length", 32'(last_len), 32'd10);
    chk_sts("R5 executing status", 8'h80);
    chk_burst("R4 zero while executing", 0);
    wr(A_FIFO, 8'h77);
    chk("R11 write during execution ignored", 32'(exe_cmd_len), 32'd10);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); exe_addr = PW'(i); #1;
      chk("R5 buffer handed to executor", 32'(exe_rdata), 32'(cmd[i]));
    end

    exec_rsp(12);
    chk_sts("R6 data available", 8'h90);
    chk_burst("R6/R4 remaining count", 12);
    for (int i = 0; i < 5; i++) fifo_pull(cmd[i % 10] ^ 8'hA5);
    chk_burst("R4 remaining after 5", 7);
    wr(A_FIFO, 8'h55);
    for (int i = 5; i < 12; i++) fifo_pull(cmd[i % 10] ^ 8'hA5);
    chk_sts("R7 available clears after last", 8'h80);
    chk_burst("R4 zero after drain", 0);
    fifo_pull(8'h00);

    // R8 retry
    wr(A_STS, 8'h02);
    chk_sts("R8 retry restores available", 8'h90);
    chk_burst("R8 full count after retry", 12);
    for (int i = 0; i < 12; i++) fifo_pull(cmd[i % 10] ^ 8'hA5);

    // R9 ready discards response
    wr(A_STS, 8'h40);
    chk_sts("R9 ready after response", 8'hC0);
    chk_burst("R9 full allowance", BMAX);

    // R3 declared length below header minimum
    set_hdr(8'h01, 32'd3);
    send(0, 5);
    chk_sts("R3 minimum six bytes", 8'hC8);
    send(5, 6);
    chk_sts("R3 expect clears at six", 8'hC0);

    // R9 discard of a partial command
    wr(A_STS, 8'h40);
    send(0, 4);
    wr(A_STS, 8'h40);
    chk_sts("R9 partial discarded", 8'hC0);
    set_hdr(8'h02, 32'd8); cmd[6] = 8'h5A; cmd[7] = 8'hC3; cmd_n = 8;
    send(0, 7);
    chk_sts("R9 new command counted from zero", 8'hC8);
    send(7, 8);
    chk_sts("R9 new command complete", 8'hC0);
    wr(A_STS, 8'h20);
    repeat (3) @(negedge clk);
    chk("R9 start count", 32'(n_start), 32'd2);
    chk("R9 new length", 32'(last_len), 32'd8);
    @(negedge clk); exe_addr = PW'(1); #1;
    chk("R9 new byte at offset 1", 32'(exe_rdata), 32'h02);
    @(negedge clk); exe_addr = PW'(7); #1;
    chk("R9 new byte at offset 7", 32'(exe_rdata), 32'hC3);

    // R10 cancel during execution
    wr(A_CAN, 8'h01);
    repeat (2) @(negedge clk);
    chk("R10 abort pulse", 32'(n_abort), 32'd1);
    chk_sts("R10 back to ready", 8'hC0);
    @(negedge clk); exe_rsp_len = PW'(5); exe_done = 1'b1;
    @(negedge clk); exe_done = 1'b0;
    chk_sts("R10 late done ignored", 8'hC0);
    chk_burst("R10 allowance after late done", BMAX);

    // R3 multi-byte big-endian length (263 = 0x107)
    set_hdr(8'h01, 32'h0000_0107);
    for (int i = 6; i < 263; i++) cmd[i] = 8'(i);
    send(0, 262);
    chk_sts("R3 big-endian length pending", 8'hC8);
    send(262, 263);
    chk_sts("R3 big-endian length reached", 8'hC0);
    wr(A_STS, 8'h40);

    // R2 cap at buffer depth, R4 free space near full
    set_hdr(8'h01, 32'd2000);
    for (int i = 6; i < DEPTH; i++) cmd[i] = 8'(i * 3);
    send(0, DEPTH - 1);
    chk_sts("R2 expecting near full", 8'hC8);
    chk_burst("R4 one byte free", 1);
    send(DEPTH - 1, DEPTH);
    chk_sts("R2 capped at depth", 8'hC0);
    wr(A_STS, 8'h20);
    repeat (3) @(negedge clk);
    chk("R2 full length handed over", 32'(last_len), 32'(DEPTH));
    wr(A_STS, 8'h40);
    repeat (2) @(negedge clk);
    chk("R10 ready aborts execution", 32'(n_abort), 32'd2);

    repeat (4) @(negedge clk);
    chk("R7 scoreboard drained", 32'(exp_q.size()), 32'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule